// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

The block sits between a processor's register bus and a byte-wide frame stream. It holds one frame per direction. To transmit, software writes a byte count and then feeds the frame one byte per write through a data port. Once the last byte arrives, the block plays the frame out on its output stream, one byte per cycle, and flags completion. On the receive side, an incoming frame from the input stream is captured whole. Software reads its length and then pops it byte by byte through a data port, and the pending count falls with every pop.

The block has three interrupt sources: transmit completion, receive data available, and a test interrupt that software can raise. One line carries all three. While receive data is flagged as available, the receive side is locked. Any frame that arrives during that time is discarded whole and counted.

Top module: `pkt_mailbox`

## Requirements
- R1: After reset the interrupt line and the output stream valid are low, and the busy word (offset 0x08), the receive count (0x0C), the transmit count (0x10) and the interrupt control word (0x14) all read zero.
- R2: Offsets 0x00 and 0x04 read the low and high halves of the constant identification parameter. Offset 0x18 reads the interrupt line index parameter.
- R3: After a non-zero count is written to 0x10 and that many bytes are written to 0x20, the frame appears on the output stream in write order, one byte per cycle, with last set only on the final byte. The transmit count reads zero from the moment the frame is taken.
- R4: A transmit count above MAX_FRAME is clamped to MAX_FRAME. Writing a count of zero is ignored. A count written while a frame is loading or sending is ignored.
- R5: Only bits 7:0 of a write to 0x20 are used. Such a write is ignored when no frame is loading.
- R6: Bit 0 of 0x14 is set in the cycle after the final output byte. If software writes 1 to bit 0 in that same cycle, the set wins.
- R7: When the final byte of an accepted input frame arrives, 0x0C holds the frame length and bit 1 of 0x14 is set. Each read of 0x1C returns the next byte in bits 7:0, with the upper bits zero, and lowers the count by one. With the count at zero, a read returns zero.
- R8: A frame that starts while bit 1 of 0x14 is set is dropped whole. The drop counter rises by one, and the held frame and its count are untouched.
- R9: Writing 1 to bit 0 or bit 1 of 0x14 clears that flag. Writing 0 to a flag bit leaves it as it is.
- R10: Writing a value with bit 31 set to 0x14 sets both a visible test flag (bit 31) and a pending test interrupt. A read of 0x14 returns bit 31 and then clears it. The pending test interrupt stays until an all-zero value is written to 0x14.
- R11: The interrupt line is high whenever the transmit-done flag, the receive-done flag or the pending test interrupt is set.
- R12: Bit 0 of 0x08 reads 1 while a transmit frame is loading or sending, or while an input frame is being received.
- R13: An input frame longer than MAX_FRAME keeps only its first MAX_FRAME bytes, and the count reads MAX_FRAME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined interrupt line |
| tx_valid | output | 1 | Output stream byte valid |
| tx_data | output | 8 | Output stream byte |
| tx_last | output | 1 | Final byte of the output frame |
| rx_valid | input | 1 | Input stream byte valid |
| rx_data | input | 8 | Input stream byte |
| rx_last | input | 1 | Final byte of the input frame |
| rx_drop_count | output | 16 | Count of input frames dropped during lockout |

## Verification
The transmit engine can raise its done flag in the same cycle that software writes 1 to clear that flag. The bench waits for the cycle in which the output stream shows the final byte, and in that same cycle it puts the clear write on the bus, so both updates land on one clock edge. It then reads the control word and expects bit 0 to still be set, which shows that the hardware set wins over the software clear.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    // Register byte offsets; software and the bench depend on these.
    localparam logic [5:0] OFS_ID_LO = 6'h00;
    localparam logic [5:0] OFS_ID_HI = 6'h04;
    localparam logic [5:0] OFS_BUSY  = 6'h08;
    localparam logic [5:0] OFS_RXCNT = 6'h0C;
    localparam logic [5:0] OFS_TXCNT = 6'h10;
    localparam logic [5:0] OFS_CTL   = 6'h14;
    localparam logic [5:0] OFS_INFO  = 6'h18;
    localparam logic [5:0] OFS_RXDAT = 6'h1C;
    localparam logic [5:0] OFS_TXDAT = 6'h20;

    // Control word bit positions.
    localparam int CTL_TXDONE = 0;
    localparam int CTL_RXDONE = 1;
    localparam int CTL_TEST   = 31;

    typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_state_e;
endpackage

// File: rtl/mbx_tx_path.sv
`timescale 1ns/1ps
module mbx_tx_path import mbx_pkg::*; #(
    parameter int MAX_FRAME = 64,
    parameter int CNT_W     = 7,
    parameter int PTR_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [31:0]      cnt_val,
    input  logic             dat_wr,
    input  logic [7:0]       dat_byte,
    output logic [CNT_W-1:0] cnt_out,
    output logic             busy,
    output logic             st_valid,
    output logic [7:0]       st_data,
    output logic             st_last
);
    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] wptr;
        logic [CNT_W-1:0] rptr;
    } tx_regs_t;

    tx_regs_t         d, q;
    logic [7:0]       mem [MAX_FRAME];
    logic             mem_we;
    logic [PTR_W-1:0] mem_wa;
    logic [CNT_W-1:0] clamp_cnt;
    logic [CNT_W-1:0] wptr_inc;
    logic             final_byte;

    assign clamp_cnt  = (cnt_val > 32'(MAX_FRAME)) ? CNT_W'(MAX_FRAME) : cnt_val[CNT_W-1:0];
    assign wptr_inc   = q.wptr + CNT_W'(1);
    assign final_byte = (q.st == TX_SEND) && (q.rptr == q.len - CNT_W'(1));

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        mem_wa = q.wptr[PTR_W-1:0];
        case (q.st)
            TX_IDLE: begin
                if (cnt_wr && cnt_val != 32'd0) begin
                    d.cnt  = clamp_cnt;
                    d.len  = clamp_cnt;
                    d.wptr = '0;
                    d.st   = TX_LOAD;
                end
            end
            TX_LOAD: begin
                if (dat_wr) begin
                    mem_we = 1'b1;
                    d.wptr = wptr_inc;
                    if (wptr_inc == q.len) begin
                        d.cnt  = '0;
                        d.rptr = '0;
                        d.st   = TX_SEND;
                    end
                end
            end
            TX_SEND: begin
                d.rptr = q.rptr + CNT_W'(1);
                if (final_byte) d.st = TX_IDLE;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= dat_byte;
    end

    assign cnt_out  = q.cnt;
    assign busy     = (q.st != TX_IDLE);
    assign st_valid = (q.st == TX_SEND);
    assign st_data  = mem[q.rptr[PTR_W-1:0]];
    assign st_last  = final_byte;

    // R4: the programmed count never exceeds the frame limit
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(MAX_FRAME));
    // R5: a data write with no frame loading leaves the engine idle
    a_r5_idle_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE && dat_wr && !cnt_wr) |=> (q.st == TX_IDLE));
endmodule

// File: rtl/mbx_rx_path.sv
`timescale 1ns/1ps
module mbx_rx_path import mbx_pkg::*; #(
    parameter int MAX_FRAME = 64,
    parameter int CNT_W     = 7,
    parameter int PTR_W     = 6,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              locked,
    input  logic              pop,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [7:0]        pop_byte,
    output logic              busy,
    output logic              frame_done,
    output logic [DROP_W-1:0] drop_cnt
);
    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  wptr;
        logic [CNT_W-1:0]  rptr;
        logic [DROP_W-1:0] drop;
    } rx_regs_t;

    rx_regs_t         d, q;
    logic [7:0]       mem [MAX_FRAME];
    logic             mem_we;
    logic [PTR_W-1:0] mem_wa;
    logic             room;
    logic             done_c;

    assign room = (q.wptr < CNT_W'(MAX_FRAME));

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        mem_wa = q.wptr[PTR_W-1:0];
        done_c = 1'b0;
        if (pop && q.cnt != '0) begin
            d.cnt  = q.cnt - CNT_W'(1);
            d.rptr = q.rptr + CNT_W'(1);
        end
        case (q.st)
            RX_IDLE: begin
                if (in_valid) begin
                    if (locked) begin
                        d.drop = q.drop + DROP_W'(1);
                        if (!in_last) d.st = RX_DROP;
                    end else begin
                        mem_we = 1'b1;
                        mem_wa = '0;
                        d.wptr = CNT_W'(1);
                        d.rptr = '0;
                        d.cnt  = '0;
                        if (in_last) begin
                            d.cnt  = CNT_W'(1);
                            done_c = 1'b1;
                        end else begin
                            d.st = RX_RECV;
                        end
                    end
                end
            end
            RX_RECV: begin
                if (in_valid) begin
                    if (room) begin
                        mem_we = 1'b1;
                        d.wptr = q.wptr + CNT_W'(1);
                    end
                    if (in_last) begin
                        d.cnt  = d.wptr;
                        d.rptr = '0;
                        done_c = 1'b1;
                        d.st   = RX_IDLE;
                    end
                end
            end
            RX_DROP: begin
                if (in_valid && in_last) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= in_data;
    end

    assign cnt_out    = q.cnt;
    assign pop_byte   = (q.cnt != '0) ? mem[q.rptr[PTR_W-1:0]] : 8'h00;
    assign busy       = (q.st == RX_RECV);
    assign frame_done = done_c;
    assign drop_cnt   = q.drop;

    // R7: a pop with data pending lowers the count by one
    a_r7_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q.cnt != '0 && !in_valid) |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));
    // R8: a frame start under lockout bumps the drop counter
    a_r8_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_IDLE && in_valid && locked) |=> (q.drop == $past(q.drop) + DROP_W'(1)));
    // R8: lockout without pops keeps the held count
    a_r8_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !pop) |=> $stable(q.cnt));
endmodule

// File: rtl/mbx_irq_ctrl.sv
`timescale 1ns/1ps
module mbx_irq_ctrl import mbx_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    input  logic        ctl_rd,
    input  logic        tx_done_set,
    input  logic        rx_done_set,
    output logic [31:0] ctl_value,
    output logic        rx_locked,
    output logic        irq
);
    typedef struct packed {
        logic txdone;
        logic rxdone;
        logic test_flag;
        logic test_irq;
    } irq_regs_t;

    irq_regs_t d, q;
    logic      clr_tx, clr_rx, raise_test, zero_wr;

    assign clr_tx     = ctl_wr && ctl_wdata[CTL_TXDONE];
    assign clr_rx     = ctl_wr && ctl_wdata[CTL_RXDONE];
    assign raise_test = ctl_wr && ctl_wdata[CTL_TEST];
    assign zero_wr    = ctl_wr && (ctl_wdata == 32'd0);

    always_comb begin
        d        = q;
        d.txdone = (q.txdone && !clr_tx) || tx_done_set;
        d.rxdone = (q.rxdone && !clr_rx) || rx_done_set;
        if (raise_test)  d.test_flag = 1'b1;
        else if (ctl_rd) d.test_flag = 1'b0;
        if (raise_test)   d.test_irq = 1'b1;
        else if (zero_wr) d.test_irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctl_value             = 32'd0;
        ctl_value[CTL_TXDONE] = q.txdone;
        ctl_value[CTL_RXDONE] = q.rxdone;
        ctl_value[CTL_TEST]   = q.test_flag;
    end

    assign rx_locked = q.rxdone;
    assign irq       = q.txdone | q.rxdone | q.test_irq;

    // R9: writing 1 to the receive flag clears it unless a new frame lands
    a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !rx_done_set) |=> !q.rxdone);
    // R10: a plain read clears the visible test flag
    a_r10_read_clears_test: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !ctl_wr) |=> !q.test_flag);
    // R10: the pending test interrupt survives reads
    a_r10_irq_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.test_irq && !ctl_wr) |=> q.test_irq);
endmodule

// File: rtl/pkt_mailbox.sv
`timescale 1ns/1ps
module pkt_mailbox import mbx_pkg::*; #(
    parameter int          MAX_FRAME = 64,
    parameter int          DROP_W    = 16,
    parameter logic [63:0] ID_VALUE  = 64'h4D42_5850_0000_0001,
    parameter int          IRQ_LINE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic [DROP_W-1:0] rx_drop_count
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int PTR_W = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;

    typedef struct packed {
        logic [31:0] rdata;
    } top_regs_t;

    top_regs_t        d, q;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_busy, rx_busy, busy;
    logic             rx_done, rx_locked;
    logic [7:0]       pop_byte;
    logic [31:0]      ctl_value;
    logic             wr_txcnt, wr_txdat, wr_ctl, rd_ctl, rd_rxdat;

    assign wr_txcnt = bus_wr && (bus_addr == OFS_TXCNT);
    assign wr_txdat = bus_wr && (bus_addr == OFS_TXDAT);
    assign wr_ctl   = bus_wr && (bus_addr == OFS_CTL);
    assign rd_ctl   = bus_rd && (bus_addr == OFS_CTL);
    assign rd_rxdat = bus_rd && (bus_addr == OFS_RXDAT);
    assign busy     = tx_busy | rx_busy;

    mbx_tx_path #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(wr_txcnt), .cnt_val(bus_wdata),
        .dat_wr(wr_txdat), .dat_byte(bus_wdata[7:0]),
        .cnt_out(tx_cnt), .busy(tx_busy),
        .st_valid(tx_valid), .st_data(tx_data), .st_last(tx_last)
    );

    mbx_rx_path #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .PTR_W(PTR_W), .DROP_W(DROP_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last),
        .locked(rx_locked), .pop(rd_rxdat),
        .cnt_out(rx_cnt), .pop_byte(pop_byte), .busy(rx_busy),
        .frame_done(rx_done), .drop_cnt(rx_drop_count)
    );

    mbx_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(wr_ctl), .ctl_wdata(bus_wdata), .ctl_rd(rd_ctl),
        .tx_done_set(tx_valid && tx_last), .rx_done_set(rx_done),
        .ctl_value(ctl_value), .rx_locked(rx_locked), .irq(irq)
    );

    always_comb begin
        d = q;
        if (bus_rd) begin
            case (bus_addr)
                OFS_ID_LO: d.rdata = ID_VALUE[31:0];
                OFS_ID_HI: d.rdata = ID_VALUE[63:32];
                OFS_BUSY:  d.rdata = {31'd0, busy};
                OFS_RXCNT: d.rdata = 32'(rx_cnt);
                OFS_TXCNT: d.rdata = 32'(tx_cnt);
                OFS_CTL:   d.rdata = ctl_value;
                OFS_INFO:  d.rdata = 32'(IRQ_LINE);
                OFS_RXDAT: d.rdata = {24'd0, pop_byte};
                default:   d.rdata = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;

    // R6: the transmit-done flag is up the cycle after the final byte
    a_r6_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> ctl_value[CTL_TXDONE]);
    // R3: the count register is already clear while the frame streams out
    a_r3_count_cleared_on_send: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_cnt == '0));
endmodule

// File: tb/tb_pkt_mailbox.sv
`timescale 1ns/1ps
module tb_pkt_mailbox;
    localparam int          MAXF  = 64;
    localparam logic [63:0] IDV   = 64'h4D42_5850_0000_0001;
    localparam int          ILINE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [15:0] rx_drop_count;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    logic [8:0] exp_q[$];
    logic [8:0] got;

    always #10 clk = ~clk;

    pkt_mailbox #(.MAX_FRAME(MAXF), .ID_VALUE(IDV), .IRQ_LINE(ILINE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_drop_count(rx_drop_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    function automatic logic [7:0] pat(input logic [7:0] base, input int i);
        return base + 8'(i * 7);
    endfunction

    // Driver: queues the expected bytes, then writes count and data.
    task automatic send_tx(input int prog, input logic [7:0] base);
        int m;
        m = (prog > MAXF) ? MAXF : prog;
        for (int i = 0; i < m; i++) exp_q.push_back({(i == m - 1), pat(base, i)});
        bus_write(6'h10, 32'(prog));
        for (int i = 0; i < m; i++) bus_write(6'h20, 32'hA5A5_A500 | 32'(pat(base, i)));
    endtask

    task automatic send_rx(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = pat(base, i); rx_last = (i == n - 1);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic drain_tx;
        int guard = 0;
        while ((exp_q.size() != 0 || tx_valid) && guard < 500) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
    endtask

    // Monitor: compares each output byte against the queue head.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1FF);
            end else begin
                got = exp_q.pop_front();
                chk("R3/R5 stream byte", {23'd0, tx_last, tx_data}, {23'd0, got});
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        bus_read(6'h08, v); chk("R1 busy", v, 0);
        bus_read(6'h0C, v); chk("R1 rxcnt", v, 0);
        bus_read(6'h10, v); chk("R1 txcnt", v, 0);
        bus_read(6'h14, v); chk("R1 ctl", v, 0);

        // R2 identification and line index
        bus_read(6'h00, v); chk("R2 id lo", v, IDV[31:0]);
        bus_read(6'h04, v); chk("R2 id hi", v, IDV[63:32]);
        bus_read(6'h18, v); chk("R2 info", v, ILINE);

        // R3 / R12 five-byte frame, busy and count while loading
        for (int i = 0; i < 5; i++) exp_q.push_back({(i == 4), pat(8'h10, i)});
        bus_write(6'h10, 5);
        bus_write(6'h20, 32'hFFFF_FF00 | 32'(pat(8'h10, 0)));
        bus_write(6'h20, 32'h1234_5600 | 32'(pat(8'h10, 1)));
        bus_read(6'h10, v); chk("R3 txcnt while loading", v, 5);
        bus_read(6'h08, v); chk("R12 busy while loading", v, 1);
        bus_write(6'h10, 9);   // R4 ignored mid-load
        for (int i = 2; i < 5; i++) bus_write(6'h20, 32'hA5A5_A500 | 32'(pat(8'h10, i)));
        drain_tx();
        bus_read(6'h10, v); chk("R3 txcnt cleared", v, 0);
        chk("R3 queue empty", exp_q.size(), 0);
        bus_read(6'h14, v); chk("R6 txdone set", v, 32'h1);
        chk("R11 irq from txdone", {31'd0, irq}, 1);
        bus_write(6'h14, 32'h0000_0002);   // R9 bit1 write, bit0 untouched
        bus_read(6'h14, v); chk("R9 bit0 kept", v, 32'h1);
        bus_write(6'h14, 32'h0000_0001);
        bus_read(6'h14, v); chk("R9 txdone cleared", v, 0);
        chk("R11 irq low", {31'd0, irq}, 0);

        // R5 data write while idle ignored; R4 zero count ignored
        bus_write(6'h20, 32'h0000_00EE);
        bus_write(6'h10, 0);
        bus_read(6'h08, v); chk("R4 zero count leaves idle", v, 0);
        send_tx(3, 8'h80);
        drain_tx();
        chk("R5 no stray byte", exp_q.size(), 0);
        bus_write(6'h14, 1);

        // R4 clamp
        bus_write(6'h10, 100);
        bus_read(6'h10, v); chk("R4 clamp", v, MAXF);
        for (int i = 0; i < MAXF; i++) exp_q.push_back({(i == MAXF - 1), pat(8'h33, i)});
        for (int i = 0; i < MAXF; i++) bus_write(6'h20, 32'(pat(8'h33, i)));
        drain_tx();
        chk("R4 clamped frame done", exp_q.size(), 0);
        bus_write(6'h14, 1);

        // R6 set versus simultaneous clear
        send_tx(1, 8'h5A);
        while (!(tx_valid && tx_last)) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h14; bus_wdata = 32'h1;
        @(negedge clk); bus_wr = 1'b0;
        bus_read(6'h14, v); chk("R6 set wins over clear", v, 32'h1);
        bus_write(6'h14, 1);

        // R7 receive and pop
        send_rx(4, 8'h40);
        bus_read(6'h0C, v); chk("R7 rxcnt", v, 4);
        bus_read(6'h14, v); chk("R7 rxdone", v, 32'h2);
        chk("R11 irq from rxdone", {31'd0, irq}, 1);
        bus_read(6'h1C, v); chk("R7 byte0", v, {24'd0, pat(8'h40, 0)});
        bus_read(6'h0C, v); chk("R7 count after pop", v, 3);

        // R8 lockout drop
        send_rx(3, 8'hC0);
        chk("R8 drop count", {16'd0, rx_drop_count}, 1);
        bus_read(6'h0C, v); chk("R8 count held", v, 3);
        bus_read(6'h1C, v); chk("R8 byte1 intact", v, {24'd0, pat(8'h40, 1)});
        bus_read(6'h1C, v); chk("R7 byte2", v, {24'd0, pat(8'h40, 2)});
        bus_read(6'h1C, v); chk("R7 byte3", v, {24'd0, pat(8'h40, 3)});
        bus_read(6'h1C, v); chk("R7 empty read", v, 0);
        bus_read(6'h0C, v); chk("R7 count zero", v, 0);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, v); chk("R9 rxdone cleared", v, 0);

        // R12 busy during receive
        fork
            send_rx(6, 8'h21);
            begin
                repeat (2) @(negedge clk);
                bus_read(6'h08, v); chk("R12 busy while receiving", v, 1);
            end
        join
        bus_read(6'h0C, v); chk("R7 six-byte count", v, 6);
        bus_write(6'h14, 32'h2);

        // R13 truncation
        send_rx(70, 8'h01);
        bus_read(6'h0C, v); chk("R13 truncated count", v, MAXF);
        bus_read(6'h1C, v); chk("R13 first byte", v, {24'd0, pat(8'h01, 0)});
        bus_write(6'h14, 32'h2);
        chk("R11 all clear", {31'd0, irq}, 0);

        // R10 test interrupt
        bus_write(6'h14, 32'h8000_0000);
        chk("R10 irq raised", {31'd0, irq}, 1);
        bus_read(6'h14, v); chk("R10 bit31 seen", v, 32'h8000_0000);
        bus_read(6'h14, v); chk("R10 bit31 cleared by read", v, 0);
        chk("R10 irq held after read", {31'd0, irq}, 1);
        bus_write(6'h14, 32'h0);
        chk("R10 irq cleared by zero write", {31'd0, irq}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule